// File: doc/BRIEF.md
# Multi-Queue FIFO Status Flag Generator

This block tracks how full each of up to four logical queues is, where all queues share one buffer, and it produces their status flags. The write side selects one queue and the read side selects one queue; each side gets a full flag, an almost-full flag, an output-valid flag and an almost-empty flag for its selected queue. Two vectors carry the almost-full and almost-empty state of every queue at once, so queues that are not selected can still be watched. All flags are active low. The data path itself is not part of the block.

The input bus and the output bus can each be narrow (9 bits) or wide (18 bits). The block keeps each queue's occupancy in 9-bit half-word units. A storage location is as wide as the wider of the two buses. When the read port is parked on the same queue as the write port, one word sits in a prefetch output register. That word adds one location of headroom, except when a wide input feeds a narrow output. The almost-full and almost-empty offsets are chosen at master reset. The bus widths are also captured at master reset.

Top module: `mq_flag_gen`

## Requirements
- R1: While master reset (`mrst_n`, synchronous, active low) is applied, every queue is emptied. Afterwards `full_n`, `afull_n`, `ov_n` and every `afull_vec_n` bit are high, and `aempty_n` and every `aempty_vec_n` bit are low.
- R2: `ov_n` goes low once the selected read queue holds at least one output word. That is after the 1st write with matched widths or a wide input, and after the 2nd write with a narrow input and a wide output. It goes high in the clock after the read that removes the last output word.
- R3: With matched widths, `full_n` goes low in the clock after write D+1 when both ports select the queue, and after write D when only the write port does (D = `DEPTH`).
- R4: With a wide input and a narrow output, `full_n` goes low after D writes even when both ports select the queue. A single narrow read from a full queue leaves it full, and the second narrow read frees a location and raises `full_n`.
- R5: With a narrow input and a wide output and both ports on the queue, `full_n` goes low after (D+1)×2 writes.
- R6: Almost-full becomes true once the write count reaches D+e−m locations, where e is 1 for the prefetch headroom case and 0 otherwise, and m is the offset. The flag goes low two clocks after the causing write. It returns high in the clock after the read that drops the count below that mark.
- R7: Almost-empty stays low until the queue holds n+1+e locations, where n is the offset. It goes high in the clock after the write that reaches that mark. It returns low two clocks after the read that drops below it.
- R8: `big_off` low at master reset selects the offsets n = m = `OFF_LO`. `big_off` high selects n = m = `OFF_HI`.
- R9: A write to a queue whose full flag is low is ignored and changes no count.
- R10: A read while `ov_n` is high is ignored and changes no count.
- R11: Bit q of `afull_vec_n` and of `aempty_vec_n` belongs to queue q. The selected-queue outputs follow `wr_q` (full, almost-full) and `rd_q` (output-valid, almost-empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Synchronous master reset, active low |
| big_off | input | 1 | Offset select, captured at master reset |
| in_narrow | input | 1 | 1 = 9-bit input bus, captured at master reset |
| out_narrow | input | 1 | 1 = 9-bit output bus, captured at master reset |
| wr_en | input | 1 | Write strobe |
| wr_q | input | QW | Write queue select |
| rd_en | input | 1 | Read strobe |
| rd_q | input | QW | Read queue select |
| full_n | output | 1 | Full flag of write queue, active low |
| afull_n | output | 1 | Almost-full flag of write queue, active low |
| ov_n | output | 1 | Output-valid flag of read queue, active low |
| aempty_n | output | 1 | Almost-empty flag of read queue, active low |
| afull_vec_n | output | NQ | Per-queue almost-full, active low |
| aempty_vec_n | output | NQ | Per-queue almost-empty, active low |

## Verification
The bench runs all four width pairings against a shared and a write-only queue selection. A design that ignored the prefetch headroom would go full or leave almost-empty one write early. A design that ignored the bus widths would raise output-valid after a single narrow write. Writes past full and reads from an empty queue are driven into the block, and the full drain-and-refill sequence is then counted. A count that wrapped or grew would show up as a wrong number of reads or as output-valid stuck low. The flag-lag cases sample almost-full and almost-empty exactly one and two clocks after the causing operation, which exposes a flag that is one stage too fast or too slow.

// File: rtl/mq_flag_gen.sv
module mq_flag_gen #(
  parameter int NQ = 4,
  parameter int DEPTH = 256,
  parameter int OFF_LO = 8,
  parameter int OFF_HI = 128,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          big_off,
  input  logic          in_narrow,
  input  logic          out_narrow,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_q,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_q,
  output logic          full_n,
  output logic          afull_n,
  output logic          ov_n,
  output logic          aempty_n,
  output logic [NQ-1:0] afull_vec_n,
  output logic [NQ-1:0] aempty_vec_n
);
  localparam int CW = $clog2(2 * DEPTH + 5);
  localparam int TW = CW + QW;

  logic          cfg_in_n, cfg_out_n, cfg_big;
  logic [CW-1:0] cnt     [NQ];
  logic [CW-1:0] cnt_nx  [NQ];
  logic [CW:0]   full_thr[NQ];
  logic [CW:0]   af_thr  [NQ];
  logic [CW:0]   ae_thr  [NQ];
  logic [NQ-1:0] ex, full_c, ov_c, af_raw, ae_raw;
  logic [NQ-1:0] af_d1, af_q, ae_d1, ae_q;
  logic          wide_slot, no_extra, wr_ok, rd_ok;
  logic [CW:0]   inw, outw, off;
  logic [TW-1:0] tot;

  function automatic logic [CW:0] scale(input logic wide, input logic [CW:0] v);
    return wide ? (v << 1) : v;
  endfunction

  assign wide_slot = !(cfg_in_n && cfg_out_n);
  assign no_extra  = !cfg_in_n && cfg_out_n;
  assign inw  = cfg_in_n  ? (CW+1)'(1) : (CW+1)'(2);
  assign outw = cfg_out_n ? (CW+1)'(1) : (CW+1)'(2);
  assign off  = cfg_big ? (CW+1)'(OFF_HI) : (CW+1)'(OFF_LO);

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      ex[q]       = (rd_q == QW'(q)) && !no_extra;
      full_thr[q] = scale(wide_slot, (CW+1)'(DEPTH) + (CW+1)'(ex[q]));
      af_thr[q]   = scale(wide_slot, (CW+1)'(DEPTH) + (CW+1)'(ex[q]) - off);
      ae_thr[q]   = scale(wide_slot, off + (CW+1)'(1) + (CW+1)'(ex[q]));
      full_c[q]   = ({1'b0, cnt[q]} + inw) > full_thr[q];
      ov_c[q]     = {1'b0, cnt[q]} >= outw;
    end
  end

  assign wr_ok = wr_en && !full_c[wr_q];
  assign rd_ok = rd_en && ov_c[rd_q];

  always_comb begin
    logic [CW:0] nx;
    for (int q = 0; q < NQ; q++) begin
      nx = {1'b0, cnt[q]};
      if (wr_ok && wr_q == QW'(q)) nx = nx + inw;
      if (rd_ok && rd_q == QW'(q)) nx = nx - outw;
      cnt_nx[q] = nx[CW-1:0];
      af_raw[q] = nx >= af_thr[q];
      ae_raw[q] = nx < ae_thr[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg_in_n  <= in_narrow;
      cfg_out_n <= out_narrow;
      cfg_big   <= big_off;
      for (int q = 0; q < NQ; q++) cnt[q] <= '0;
      af_d1 <= '0;
      af_q  <= '0;
      ae_d1 <= '1;
      ae_q  <= '1;
    end else begin
      for (int q = 0; q < NQ; q++) cnt[q] <= cnt_nx[q];
      af_d1 <= af_raw;
      af_q  <= af_d1 & af_raw;
      ae_d1 <= ae_raw;
      ae_q  <= ae_d1 & ae_raw;
    end
  end

  assign full_n       = !full_c[wr_q];
  assign ov_n         = !ov_c[rd_q];
  assign afull_vec_n  = ~af_q;
  assign aempty_vec_n = ~ae_q;
  assign afull_n      = ~af_q[wr_q];
  assign aempty_n     = ~ae_q[rd_q];

  always_comb begin
    tot = '0;
    for (int q = 0; q < NQ; q++) tot = tot + TW'(cnt[q]);
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !mrst_n |=> (full_n && afull_n && ov_n && !aempty_n &&
                 afull_vec_n == '1 && aempty_vec_n == '0)); // R1
  AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!mrst_n)
    (wr_en && !full_n && !rd_en) |=> tot == $past(tot)); // R9
  AST_EMPTY_IGNORES_READ: assert property (@(posedge clk) disable iff (!mrst_n)
    (rd_en && ov_n && !wr_en) |=> tot == $past(tot)); // R10

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!mrst_n)
      cnt[g] <= CW'(2 * DEPTH + 2)); // R3
    AST_AF_LATE: assert property (@(posedge clk) disable iff (!mrst_n)
      $fell(afull_vec_n[g]) |-> $past(af_d1[g])); // R6
  end
endmodule

// File: tb/mq_flag_gen_bench.sv
module mq_flag_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int D = 32;

  logic clk = 0;
  logic mrst_n = 0, big_off = 0, in_narrow = 0, out_narrow = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_q = 0, rd_q = 0;
  logic full_n, afull_n, ov_n, aempty_n;
  logic [NQ-1:0] afull_vec_n, aempty_vec_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mq_flag_gen #(.NQ(NQ), .DEPTH(D), .OFF_LO(4), .OFF_HI(8)) u_mq_flag_gen (
    .clk, .mrst_n, .big_off, .in_narrow, .out_narrow,
    .wr_en, .wr_q, .rd_en, .rd_q,
    .full_n, .afull_n, .ov_n, .aempty_n, .afull_vec_n, .aempty_vec_n);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [NQ-1:0] act, input logic [NQ-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r);
    wr_en = w;
    rd_en = r;
    @(negedge clk);
    wr_en = 0;
    rd_en = 0;
  endtask

  task automatic mreset(input logic in_n, input logic out_n, input logic big);
    mrst_n = 0;
    in_narrow = in_n;
    out_narrow = out_n;
    big_off = big;
    @(negedge clk);
    @(negedge clk);
    mrst_n = 1;
  endtask

  task automatic t_reset;
    mreset(0, 0, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R1 ov_n", ov_n, 1);
    chk("R1 aempty_n", aempty_n, 0);
    chkv("R1 afull_vec_n", afull_vec_n, 4'b1111);
    chkv("R1 aempty_vec_n", aempty_vec_n, 4'b0000);
  endtask

  task automatic t_matched_shared;
    mreset(0, 0, 0);
    wr_q = 0; rd_q = 0;
    op(1, 0);
    chk("R2 ov after 1st write", ov_n, 0);
    repeat (4) op(1, 0);
    chk("R7 ae still active at 5", aempty_n, 0);
    op(1, 0);
    chk("R7 ae clears at n+2", aempty_n, 1);
    repeat (23) op(1, 0);
    chk("R6 af one clock after write 29", afull_n, 1);
    op(0, 0);
    chk("R6 af two clocks after write 29", afull_n, 0);
    repeat (3) op(1, 0);
    chk("R3 not full at D", full_n, 1);
    op(1, 0);
    chk("R3 full at D+1", full_n, 0);
    op(1, 0);
    chk("R9 write while full", full_n, 0);
    for (int r = 1; r <= 33; r++) begin
      op(0, 1);
      if (r == 1) chk("R3 full clears on read", full_n, 1);
      if (r == 4) chk("R6 af holds above mark", afull_n, 0);
      if (r == 5) chk("R6 af clears one clock", afull_n, 1);
      if (r == 28) chk("R7 ae one clock after read", aempty_n, 1);
      if (r == 29) chk("R7 ae two clocks after read", aempty_n, 0);
      if (r == 32) chk("R9 last word still there", ov_n, 0);
      if (r == 33) chk("R2 ov clears on last read", ov_n, 1);
    end
    op(0, 1);
    op(1, 0);
    chk("R10 ov after refill", ov_n, 0);
    op(0, 1);
    chk("R10 empty read did not underflow", ov_n, 1);
  endtask

  task automatic t_write_only;
    mreset(0, 0, 0);
    wr_q = 0; rd_q = 1;
    repeat (4) op(1, 0);
    chkv("R11 ae vec at 4", aempty_vec_n, 4'b0000);
    op(1, 0);
    chkv("R11 ae vec at n+1", aempty_vec_n, 4'b0001);
    chk("R11 aempty_n follows rd_q", aempty_n, 0);
    chk("R11 ov_n follows rd_q", ov_n, 1);
    repeat (23) op(1, 0);
    op(0, 0);
    chkv("R11 af vec at D-m", afull_vec_n, 4'b1110);
    chk("R6 af write-only", afull_n, 0);
    repeat (3) op(1, 0);
    chk("R3 write-only not full at D-1", full_n, 1);
    op(1, 0);
    chk("R3 write-only full at D", full_n, 0);
  endtask

  task automatic t_narrow_in;
    mreset(1, 0, 0);
    wr_q = 2; rd_q = 2;
    op(1, 0);
    chk("R2 narrow in one write", ov_n, 1);
    op(1, 0);
    chk("R2 narrow in two writes", ov_n, 0);
    repeat (9) op(1, 0);
    chk("R7 narrow in ae at 11", aempty_n, 0);
    op(1, 0);
    chk("R7 narrow in ae at 12", aempty_n, 1);
    repeat (53) op(1, 0);
    chk("R5 not full at 65", full_n, 1);
    op(1, 0);
    chk("R5 full at 66", full_n, 0);
  endtask

  task automatic t_narrow_out;
    mreset(0, 1, 0);
    wr_q = 3; rd_q = 3;
    op(1, 0);
    chk("R2 wide in one write", ov_n, 0);
    repeat (30) op(1, 0);
    chk("R4 not full at D-1", full_n, 1);
    op(1, 0);
    chk("R4 full at D", full_n, 0);
    op(0, 1);
    chk("R4 one narrow read keeps full", full_n, 0);
    op(0, 1);
    chk("R4 second narrow read frees", full_n, 1);
  endtask

  task automatic t_big_offset;
    mreset(0, 0, 1);
    wr_q = 0; rd_q = 0;
    repeat (9) op(1, 0);
    chk("R8 big ae at 9", aempty_n, 0);
    op(1, 0);
    chk("R8 big ae at 10", aempty_n, 1);
    repeat (14) op(1, 0);
    op(0, 0);
    chk("R8 big af at 24", afull_n, 1);
    op(1, 0);
    op(0, 0);
    chk("R8 big af at 25", afull_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_matched_shared();
    t_write_only();
    t_narrow_in();
    t_narrow_out();
    t_big_offset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule